// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for an integrating analog-to-digital converter of the dual-slope kind. It repeats a conversion frame made of a zeroing phase, a fixed-length phase in which the unknown input is integrated, and a discharge phase in which a reference of opposite sign drives the integrator back to zero. It provides one enable per analog phase and a reference polarity select. The sampled comparator output serves two purposes. At the end of input integration it fixes the sign. During discharge it marks the zero crossing.

All phase timing is counted in divided counts, where one count is `DIV` cycles of the oscillator clock. The number of discharge counts that elapse before the crossing is the magnitude of the reading. Full scale is `DEINT_MAX` counts, twice the input integration length. Magnitude, sign and an overrange flag are published together with a one-cycle valid strobe. The zeroing phase that follows absorbs the counts the discharge did not use, so the frame length stays steady.

Top module: `dsadc_sequencer`

## Requirements
- R1: Phases run in the fixed order zeroing, input integration, discharge, then zeroing again. After reset the block leaves its idle state at the first divided count and starts with a zeroing phase of `AZ_MAX` counts.
- R2: One divided count spans `DIV` clock cycles. The input integration phase lasts exactly `INT_COUNTS` counts, which is `INT_COUNTS*DIV` cycles of `sig_en`.
- R3: While reset is high and in the idle cycles before the first count, `az_en`, `sig_en` and `ref_en` are all 0. From then on exactly one of them is 1 in every cycle.
- R4: If the synchronized comparator is 1 at the last count of input integration, the input is positive: `ref_neg` is 1 for the whole discharge and `rd_neg` is 0. If the comparator is 0, `ref_neg` is 0 and `rd_neg` is 1.
- R5: The comparator passes through two flip-flops. The discharge ends at the first count at which the synchronized comparator differs from the value latched in R4. `rd_mag` is the number of counts that completed before that count, from 0 to `DEINT_MAX`. A comparator change driven 4j+1 cycles after `ref_en` rises yields j when `DIV`=4.
- R6: If no crossing is seen by the count at which the magnitude would exceed `DEINT_MAX`, the discharge ends, `rd_ovr` is 1 and `rd_mag` is `DEINT_MAX`. Otherwise `rd_ovr` is 0.
- R7: Each zeroing phase after a discharge lasts `FRAME - INT_COUNTS - rd_mag` counts, held within `AZ_MIN` to `AZ_MAX`.
- R8: `rd_mag`, `rd_neg` and `rd_ovr` change together in the cycle in which `rd_valid` is 1, and they hold between strobes. `rd_valid` lasts one cycle and coincides with the first cycle of the next zeroing phase. All three read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Comparator output, asynchronous; 1 means the integrator is above zero |
| az_en | output | 1 | Zeroing phase switch enable |
| sig_en | output | 1 | Input integration switch enable |
| ref_en | output | 1 | Reference discharge switch enable |
| ref_neg | output | 1 | 1 selects the negative reference for discharge |
| rd_mag | output | $clog2(FRAME+1) | Magnitude of the last reading in counts |
| rd_neg | output | 1 | Sign of the last reading, 1 for negative |
| rd_ovr | output | 1 | Last reading was over range |
| rd_valid | output | 1 | One-cycle strobe marking a new reading |

## Verification
On every cycle the assertions check the one-hot switch enables and the legal phase successions. They also check that phases change only on a divided count, that the reference polarity holds through discharge, and that the strobe lasts one cycle while the reading stays put between strobes. Only the directed scenarios can show the exact cycle counts. These are the integration and zeroing lengths, the magnitude produced by a comparator change at a chosen point behind the synchronizer, the clamp of the zeroing length, and the sign derived from the comparator level.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_AZ    = 2'd1,
    PH_SIG   = 2'd2,
    PH_DEINT = 2'd3
  } phase_t;

  // Zeroing length that keeps the frame steady, saturated to the legal window.
  function automatic int az_fill(input int frame, input int integ, input int used,
                                 input int lo, input int hi);
    int rem;
    rem = frame - integ - used;
    if (rem < lo) rem = lo;
    if (rem > hi) rem = hi;
    return rem;
  endfunction

endpackage

// File: rtl/dsadc_tick_gen.sv
module dsadc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst)               div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dsadc_cmp_sync.sv
module dsadc_cmp_sync (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic cmp_s
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= cmp_in;
      sync_q <= meta_q;
    end
  end

  assign cmp_s = sync_q;
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int CW         = 12,
  parameter int INT_COUNTS = 1000,
  parameter int DEINT_MAX  = 2000,
  parameter int FRAME      = 4000,
  parameter int AZ_MIN     = 1000,
  parameter int AZ_MAX     = 3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmp_s,
  output logic          az_en,
  output logic          sig_en,
  output logic          ref_en,
  output logic          ref_neg,
  output logic          done,
  output logic [CW-1:0] done_mag,
  output logic          done_neg,
  output logic          done_ovr
);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_COUNTS - 1);
  localparam logic [CW-1:0] DE_FULL  = CW'(DEINT_MAX);
  localparam logic [CW-1:0] AZ_START = CW'(AZ_MAX);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] az_len_q, az_len_d;
  logic          pol_q, pol_d;
  logic          fin_cross, fin_ovr;
  logic          az_q, sig_q, ref_q;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    az_len_d  = az_len_q;
    pol_d     = pol_q;
    fin_cross = 1'b0;
    fin_ovr   = 1'b0;
    if (tick) begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_AZ;
          cnt_d   = '0;
        end
        PH_AZ: begin
          if (cnt_q == az_len_q - 1'b1) begin
            phase_d = PH_SIG;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_SIG: begin
          if (cnt_q == INT_LAST) begin
            phase_d = PH_DEINT;
            cnt_d   = '0;
            pol_d   = cmp_s;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cmp_s != pol_q)      fin_cross = 1'b1;
          else if (cnt_q == DE_FULL) fin_ovr  = 1'b1;
          else                      cnt_d    = cnt_q + 1'b1;
          if (fin_cross || fin_ovr) begin
            phase_d  = PH_AZ;
            cnt_d    = '0;
            az_len_d = CW'(az_fill(FRAME, INT_COUNTS, int'(cnt_q), AZ_MIN, AZ_MAX));
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      az_len_q <= AZ_START;
      pol_q    <= 1'b0;
      az_q     <= 1'b0;
      sig_q    <= 1'b0;
      ref_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      az_len_q <= az_len_d;
      pol_q    <= pol_d;
      az_q     <= (phase_d == PH_AZ);
      sig_q    <= (phase_d == PH_SIG);
      ref_q    <= (phase_d == PH_DEINT);
    end
  end

  assign az_en    = az_q;
  assign sig_en   = sig_q;
  assign ref_en   = ref_q;
  assign ref_neg  = pol_q;
  assign done     = fin_cross | fin_ovr;
  assign done_mag = fin_ovr ? DE_FULL : cnt_q;
  assign done_neg = ~pol_q;
  assign done_ovr = fin_ovr;

  assert_one_switch_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |-> ($countones({az_q, sig_q, ref_q}) == 1));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !(az_q || sig_q || ref_q));

  assert_az_then_sig_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q) && $past(phase_q) == PH_AZ) |-> (phase_q == PH_SIG));

  assert_sig_then_ref_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q) && $past(phase_q) == PH_SIG) |-> (phase_q == PH_DEINT));

  assert_ref_then_az_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q) && $past(phase_q) == PH_DEINT) |-> (phase_q == PH_AZ));

  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> $past(tick));

  assert_polarity_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ref_q && $past(ref_q)) |-> $stable(ref_neg));

  assert_finish_in_ref_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ref_q);
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
  parameter int CW        = 12,
  parameter int DEINT_MAX = 2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] mag_in,
  input  logic          neg_in,
  input  logic          ovr_in,
  output logic [CW-1:0] mag,
  output logic          neg,
  output logic          ovr,
  output logic          valid
);
  localparam logic [CW-1:0] FULL = CW'(DEINT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      mag   <= '0;
      neg   <= 1'b0;
      ovr   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) begin
        mag <= mag_in;
        neg <= neg_in;
        ovr <= ovr_in;
      end
    end
  end

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(mag) && $stable(neg) && $stable(ovr)));

  assert_mag_bound_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> (mag <= FULL));

  assert_ovr_full_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && ovr) |-> (mag == FULL));
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer #(
  parameter int DIV        = 4,
  parameter int INT_COUNTS = 1000,
  parameter int DEINT_MAX  = 2000,
  parameter int FRAME      = 4000,
  parameter int AZ_MIN     = 1000,
  parameter int AZ_MAX     = 3000,
  localparam int CW        = $clog2(FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_in,
  output logic          az_en,
  output logic          sig_en,
  output logic          ref_en,
  output logic          ref_neg,
  output logic [CW-1:0] rd_mag,
  output logic          rd_neg,
  output logic          rd_ovr,
  output logic          rd_valid
);
  logic          tick;
  logic          cmp_s;
  logic          done;
  logic [CW-1:0] done_mag;
  logic          done_neg;
  logic          done_ovr;

  dsadc_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dsadc_cmp_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .cmp_in (cmp_in),
    .cmp_s  (cmp_s)
  );

  dsadc_phase_ctrl #(
    .CW         (CW),
    .INT_COUNTS (INT_COUNTS),
    .DEINT_MAX  (DEINT_MAX),
    .FRAME      (FRAME),
    .AZ_MIN     (AZ_MIN),
    .AZ_MAX     (AZ_MAX)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmp_s    (cmp_s),
    .az_en    (az_en),
    .sig_en   (sig_en),
    .ref_en   (ref_en),
    .ref_neg  (ref_neg),
    .done     (done),
    .done_mag (done_mag),
    .done_neg (done_neg),
    .done_ovr (done_ovr)
  );

  dsadc_result_reg #(
    .CW        (CW),
    .DEINT_MAX (DEINT_MAX)
  ) u_res (
    .clk    (clk),
    .rst    (rst),
    .load   (done),
    .mag_in (done_mag),
    .neg_in (done_neg),
    .ovr_in (done_ovr),
    .mag    (rd_mag),
    .neg    (rd_neg),
    .ovr    (rd_ovr),
    .valid  (rd_valid)
  );

  assert_valid_opens_zeroing_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> az_en);
endmodule

// File: tb/sim_dsadc_sequencer.sv
module sim_dsadc_sequencer;
  localparam int DIV  = 4;
  localparam int INTC = 20;
  localparam int DMAX = 40;
  localparam int FRM  = 76;
  localparam int AZLO = 20;
  localparam int AZHI = 60;
  localparam int CW   = $clog2(FRM + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_in = 1'b0;
  logic          az_en, sig_en, ref_en, ref_neg;
  logic [CW-1:0] rd_mag;
  logic          rd_neg, rd_ovr, rd_valid;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dsadc_sequencer #(
    .DIV(DIV), .INT_COUNTS(INTC), .DEINT_MAX(DMAX),
    .FRAME(FRM), .AZ_MIN(AZLO), .AZ_MAX(AZHI)
  ) u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in),
    .az_en(az_en), .sig_en(sig_en), .ref_en(ref_en), .ref_neg(ref_neg),
    .rd_mag(rd_mag), .rd_neg(rd_neg), .rd_ovr(rd_ovr), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_az(input int mag);
    int r;
    r = FRM - INTC - mag;
    if (r < AZLO) r = AZLO;
    if (r > AZHI) r = AZHI;
    return r;
  endfunction

  // Reset state, then the first zeroing phase.
  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    check(!(az_en || sig_en || ref_en), "R3 enables low in reset", int'({az_en, sig_en, ref_en}), 0);
    check(rd_valid == 0 && rd_mag == 0 && !rd_neg && !rd_ovr, "R8 reading clear after reset",
          int'(rd_mag), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!(az_en || sig_en || ref_en), "R3 idle before first count", int'({az_en, sig_en, ref_en}), 0);
    n = 0;
    while (!az_en) begin n++; @(negedge clk); end
    check(n == DIV - 1, "R1 idle leaves at first count", n, DIV - 1);
    n = 0;
    while (az_en) begin
      n++;
      if ($countones({az_en, sig_en, ref_en}) != 1)
        check(0, "R3 one enable", int'({az_en, sig_en, ref_en}), 4);
      @(negedge clk);
    end
    check(n == DIV * AZHI, "R1 first zeroing length", n, DIV * AZHI);
    check(sig_en == 1, "R1 integration follows zeroing", int'(sig_en), 1);
  endtask

  // One conversion; pos is the comparator level during integration.
  task automatic t_conv(input bit pos, input int j, input bit over);
    int n;
    int mexp;
    cmp_in = pos;
    while (!sig_en) @(negedge clk);
    n = 0;
    while (sig_en) begin n++; @(negedge clk); end
    check(n == DIV * INTC, "R2 integration length", n, DIV * INTC);
    check(ref_en == 1, "R1 discharge follows integration", int'(ref_en), 1);
    check(ref_neg == pos, "R4 reference polarity", int'(ref_neg), int'(pos));
    if (!over) begin
      repeat (DIV * j + 1) @(negedge clk);
      cmp_in = ~pos;
    end
    n = 0;
    while (!rd_valid) begin
      if (ref_en && ref_neg != pos) check(0, "R4 polarity held", int'(ref_neg), int'(pos));
      n++;
      @(negedge clk);
    end
    mexp = over ? DMAX : j;
    check(int'(rd_mag) == mexp, "R5 R6 magnitude", int'(rd_mag), mexp);
    check(rd_neg == !pos, "R4 sign", int'(rd_neg), int'(!pos));
    check(rd_ovr == over, "R6 overrange flag", int'(rd_ovr), int'(over));
    check(az_en == 1, "R8 strobe at zeroing start", int'(az_en), 1);
    n = 0;
    while (az_en) begin
      n++;
      @(negedge clk);
      if (n == 1) check(rd_valid == 0, "R8 strobe one cycle", int'(rd_valid), 0);
    end
    check(n == DIV * exp_az(mexp), "R7 zeroing length", n, DIV * exp_az(mexp));
    check(int'(rd_mag) == mexp && rd_neg == !pos, "R8 reading held", int'(rd_mag), mexp);
  endtask

  initial begin
    t_reset();
    t_conv(1'b1, 5, 1'b0);
    t_conv(1'b0, 12, 1'b0);
    t_conv(1'b1, 0, 1'b0);
    t_conv(1'b0, 38, 1'b0);
    t_conv(1'b1, 0, 1'b1);
    t_conv(1'b0, 0, 1'b1);
    t_conv(1'b1, 30, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule